// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets software reach the management registers of external Ethernet PHYs over a two-wire MDIO bus. Software sees two 32-bit words on a small register bus. One word carries the target PHY address, the PHY register number, the direction of the access, a code that names the frequency band of the system clock, and a start/busy flag. The other word carries the 16-bit value to be written or the value that came back.

Setting the start flag while the block is idle launches one Clause 22 frame. The block derives the management clock from the system clock with a ratio picked by the band code, so that the management clock never exceeds 2.5 MHz. It shifts the frame out on MDIO, releases the line for the turnaround and data of a read, and captures the returned bits on the rising clock edge. The busy flag drops by itself once the final bit period has completed. Software polls it before it reads the result or starts the next access.

The register bus is a plain write strobe with an address and data. Read data is a combinational decode of the address. There is no back-pressure: a write that arrives during a frame is dropped.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The command word sits at byte offset 0x10 and the data word at 0x14. In the command word, bit 0 is busy, bit 1 is the direction (1 write, 0 read), bits 4:2 are the band code, bits 10:6 are the PHY register number and bits 15:11 are the PHY address. Reads of the command word return the stored fields in these positions, with all other bits zero. Reads of the data word return its 16-bit value in bits 15:0. Both words read as zero after reset.
- R2: A write to 0x10 with bit 0 set, while idle, makes busy read 1 from the next cycle on. Busy returns to 0 by itself when the frame ends.
- R3: One management clock period lasts this many system clocks: code 2 → 14, code 3 → 24, code 0 → 40, code 1 → 60, code 4 → 100, codes 5, 6 and 7 → 124. The clock is low for the first half of each bit period and high for the second half.
- R4: While idle, the management clock is held high and the MDIO output enable is low.
- R5: A frame is 64 bit periods long, sent MSB first: 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register number, 2 turnaround bits, 16 data bits.
- R6: In a read, the output enable is low from bit period 46 to the end of the frame. The bits presented on mdio_i in periods 48 to 63 are sampled at the rising clock edge. After busy clears, the data word holds them, with the first one received as bit 15.
- R7: In a write, the block drives the turnaround as 1 then 0, followed by the data word MSB first. It keeps the output enable high for all 64 periods.
- R8: Writes to either word while busy is set change neither the frame in progress nor the stored words.
- R9: Busy clears exactly 64 × ratio cycles after the start, after the high half of the last bit period.
- R10: The driven MDIO value changes only while the management clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable (1 drives the pad) |

## Verification
The hardest case to reach from the ports is a register write that lands in the middle of a frame. It has to be timed against the divider phase, and the only sign that it was ignored is a frame that carries on intact and stored words that read back unchanged afterwards. The bench fires a data write and a start-command write five bit periods into selected transactions. It keeps comparing every cycle of the frame against a frame built arithmetically from the original command, then reads both words back. A behavioural responder returns a per-address pattern on mdio_i, so every band code and both directions are swept with cycle-exact clock, enable and data expectations.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam logic [7:0] OFF_CMD  = 8'h10;
  localparam logic [7:0] OFF_DATA = 8'h14;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regn;
    logic [2:0] band;
    logic       wr;
  } mdio_cmd_t;

  // system clocks per management clock period, keeping mdc at or below 2.5 MHz
  function automatic logic [7:0] band_ratio(input logic [2:0] band);
    case (band)
      3'd0:    band_ratio = 8'd40;
      3'd1:    band_ratio = 8'd60;
      3'd2:    band_ratio = 8'd14;
      3'd3:    band_ratio = 8'd24;
      3'd4:    band_ratio = 8'd100;
      default: band_ratio = 8'd124;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] ratio,
  output logic             mdc,
  output logic             rise_tick,
  output logic             bit_end
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;

  assign half      = ratio >> 1;
  assign bit_end   = run && (cnt == ratio - 1'b1);
  assign rise_tick = run && (cnt == half);
  assign mdc       = !(run && (cnt < half));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (bit_end) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mdio_i,
  input  logic              rise_tick,
  input  logic              bit_end,
  output logic              busy,
  output logic [CNT_W-1:0]  ratio,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HDR_LEN    = PRE_LEN + 14;
  localparam int DATA_START = HDR_LEN + 2;
  localparam int FRAME_LEN  = DATA_START + DATA_W;
  localparam int IDX_W      = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] shreg;
  logic [IDX_W-1:0]     idx;
  logic                 is_wr;
  logic                 last_bit;

  assign last_bit = (idx == IDX_W'(FRAME_LEN - 1));
  assign mdio_o   = shreg[FRAME_LEN-1];
  assign mdio_oe  = busy && (is_wr || (idx < IDX_W'(HDR_LEN)));
  assign rd_done  = busy && bit_end && last_bit && !is_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      idx     <= '0;
      is_wr   <= 1'b0;
      busy    <= 1'b0;
      ratio   <= '0;
      rd_data <= '0;
    end else if (start && !busy) begin
      shreg <= {{PRE_LEN{1'b1}}, 2'b01, (cmd.wr ? 2'b01 : 2'b10), cmd.phy, cmd.regn,
                (cmd.wr ? {2'b10, wr_data} : {(DATA_W + 2){1'b1}})};
      idx   <= '0;
      is_wr <= cmd.wr;
      busy  <= 1'b1;
      ratio <= CNT_W'(band_ratio(cmd.band));
    end else if (busy) begin
      if (rise_tick && !is_wr && (idx >= IDX_W'(DATA_START)))
        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      if (bit_end) begin
        shreg <= {shreg[FRAME_LEN-2:0], 1'b1};
        if (last_bit) busy <= 1'b0;
        else          idx  <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int CNT_W   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int DATA_W = 16;

  mdio_cmd_t          cmd_q;
  logic [DATA_W-1:0]  data_q;
  logic               busy_q;
  logic               wr_cmd, wr_dat, start;
  logic [CNT_W-1:0]   ratio;
  logic               rise_tick, bit_end, rd_done;
  logic [DATA_W-1:0]  rd_data;
  logic               unused_wbits;

  assign unused_wbits = ^{reg_wdata[31:16], reg_wdata[5]};
  assign wr_cmd = reg_wr && (reg_addr == OFF_CMD) && !busy_q;
  assign wr_dat = reg_wr && (reg_addr == OFF_DATA) && !busy_q;
  assign start  = wr_cmd && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_cmd) cmd_q <= '{phy: reg_wdata[15:11], regn: reg_wdata[10:6],
                              band: reg_wdata[4:2], wr: reg_wdata[1]};
      if (wr_dat)       data_q <= reg_wdata[DATA_W-1:0];
      else if (rd_done) data_q <= rd_data;
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_CMD:  reg_rdata = {16'h0, cmd_q.phy, cmd_q.regn, 1'b0, cmd_q.band, cmd_q.wr, busy_q};
      OFF_DATA: reg_rdata = {16'h0, data_q};
      default:  reg_rdata = '0;
    endcase
  end

  mdio_clk_div #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .ratio(ratio),
    .mdc(mdc), .rise_tick(rise_tick), .bit_end(bit_end)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd('{phy: reg_wdata[15:11],
      regn: reg_wdata[10:6], band: reg_wdata[4:2], wr: reg_wdata[1]}),
    .wr_data(data_q), .mdio_i(mdio_i), .rise_tick(rise_tick), .bit_end(bit_end),
    .busy(busy_q), .ratio(ratio), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_done(rd_done), .rd_data(rd_data)
  );
endmodule

// File: rtl/mdio_mgmt_master_checker.sv
module mdio_mgmt_master_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h10 && reg_wdata[0] && !busy) |=> busy);

  p_idle_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdc && !mdio_oe));

  p_first_half_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mdc);

  p_clear_after_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mdc));

  p_data_moves_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && mdio_o != $past(mdio_o)) |-> !mdc);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy_q), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h10;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_ratio(input logic [2:0] band);
    int r;
    if (band == 3'd2) r = 14;
    else if (band == 3'd3) r = 24;
    else if (band == 3'd0) r = 40;
    else if (band == 3'd1) r = 60;
    else if (band == 3'd4) r = 100;
    else r = 124;
    return r;
  endfunction

  function automatic logic [15:0] phy_resp(input logic [4:0] phy, input logic [4:0] rg);
    return 16'((int'(phy) * 2221 + int'(rg) * 97) ^ 16'hC3A5);
  endfunction

  function automatic logic frame_bit(input int k, input bit wr, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] dat);
    logic b;
    if (k < 32) b = 1'b1;
    else if (k == 32) b = 1'b0;
    else if (k == 33) b = 1'b1;
    else if (k == 34) b = !wr;
    else if (k == 35) b = wr;
    else if (k < 41) b = phy[40 - k];
    else if (k < 46) b = rg[45 - k];
    else if (k == 46) b = 1'b1;
    else if (k == 47) b = 1'b0;
    else b = dat[63 - k];
    return b;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0; reg_addr = 8'h10;
  endtask

  task automatic run_xact(input bit wr, input logic [2:0] band, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [15:0] dat, input bit poke);
    int r = exp_ratio(band);
    int total = 64 * r;
    int e_mdc = 0, e_oe = 0, e_o = 0, e_busy = 0, e_edge = 0;
    bit b_first = 0, b_last = 1;
    logic prev_o = 1'b1, prev_mdc = 1'b1, prev_oe = 1'b0;
    logic [15:0] resp = phy_resp(phy, rg);
    if (wr) bus_write(8'h14, {16'h0, dat});
    bus_write(8'h10, {16'h0, phy, rg, 1'b0, band, wr, 1'b1});
    for (int c = 0; c <= total; c++) begin
      int k = c / r;
      bit xm, xoe, xb;
      @(negedge clk);
      xm  = (c < total) ? ((c % r) >= r / 2) : 1'b1;
      xoe = (c < total) && (wr || k < 46);
      xb  = (c < total);
      if (mdc !== xm) e_mdc++;
      if (mdio_oe !== xoe) e_oe++;
      if (xoe && mdio_o !== frame_bit(k, wr, phy, rg, dat)) e_o++;
      if (mdio_oe && prev_oe && mdio_o !== prev_o && mdc && prev_mdc) e_edge++;
      if (!(poke && c == 5 * r + 1)) begin
        if (reg_rdata[0] !== xb) e_busy++;
        if (c == 0) b_first = reg_rdata[0];
        if (c == total) b_last = reg_rdata[0];
      end
      prev_o = mdio_o; prev_mdc = mdc; prev_oe = mdio_oe;
      // behavioural responder
      if (!wr && k >= 48 && k < 64) mdio_i = resp[63 - k];
      else if (!wr && k == 47) mdio_i = 1'b0;
      else mdio_i = 1'b1;
      if (poke && c == 5 * r) begin
        reg_wr = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h0000_5A5A;
      end else if (poke && c == 5 * r + 1) begin
        reg_addr = 8'h10; reg_wdata = {16'h0, ~phy, ~rg, 1'b0, ~band, ~wr, 1'b1};
      end else if (poke && c == 5 * r + 2) begin
        reg_wr = 1'b0;
      end
    end
    check(e_mdc == 0, "R3", "mdc phase errors", e_mdc, 0);
    check(e_oe == 0, wr ? "R7" : "R6", "output enable errors", e_oe, 0);
    check(e_o == 0, wr ? "R7" : "R5", "frame bit errors", e_o, 0);
    check(e_edge == 0, "R10", "mdio change while mdc high", e_edge, 0);
    check(b_first == 1 && b_last == 0, "R2", "busy at start/end", {b_first, b_last}, 2'b10);
    check(e_busy == 0, "R9", "busy timing errors", e_busy, 0);
    if (poke) check(e_o == 0 && e_oe == 0, "R8", "frame disturbed by mid-frame write",
                    e_o + e_oe, 0);
    reg_addr = 8'h14; #1;
    check(reg_rdata == {16'h0, (wr ? dat : resp)}, poke ? "R8" : (wr ? "R1" : "R6"),
          "data word after frame", reg_rdata, {16'h0, (wr ? dat : resp)});
    reg_addr = 8'h10; #1;
    check(reg_rdata == {16'h0, phy, rg, 1'b0, band, wr, 1'b0}, poke ? "R8" : "R1",
          "command word after frame", reg_rdata, {16'h0, phy, rg, 1'b0, band, wr, 1'b0});
    repeat (5) @(negedge clk);
    check(mdc === 1'b1 && mdio_oe === 1'b0 && reg_rdata[0] === 1'b0, "R4",
          "idle lines", {mdc, mdio_oe, reg_rdata[0]}, 3'b100);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    reg_addr = 8'h10; #1;
    check(reg_rdata == 32'h0, "R1", "command word after reset", reg_rdata, 0);
    reg_addr = 8'h14; #1;
    check(reg_rdata == 32'h0, "R1", "data word after reset", reg_rdata, 0);
    check(mdc === 1'b1 && mdio_oe === 1'b0, "R4", "lines after reset", {mdc, mdio_oe}, 2'b10);
    reg_addr = 8'h10;
    // every band code, both directions
    for (int b = 0; b < 8; b++) begin
      for (int w = 0; w < 2; w++) begin
        run_xact(w[0], 3'(b), 5'(b * 4 + 1), 5'(b * 3 + w), 16'(b * 4663 + 16'h1234),
                 b[0]);
      end
    end
    // address and data corner values at the fastest ratio
    run_xact(1'b1, 3'd2, 5'd31, 5'd31, 16'hFFFF, 1'b0);
    run_xact(1'b0, 3'd2, 5'd31, 5'd31, 16'h0000, 1'b1);
    run_xact(1'b0, 3'd2, 5'd0, 5'd0, 16'h0000, 1'b0);
    run_xact(1'b1, 3'd2, 5'd0, 5'd0, 16'h0000, 1'b1);
    for (int i = 0; i < 6; i++)
      run_xact(i[0], 3'd2, 5'(i * 9), 5'(31 - i * 5), 16'(i * 8191 + 16'h00A5), 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule